// File: doc/BRIEF.md
# Two-Level Parallel Wide Comparator

This block decides the magnitude relation of two unsigned 24-bit words and drives three flags: greater, less and equal. It does not use a ripple chain of nibble comparators. It arranges six copies of one cascadable nibble comparator in two levels, so the result settles after two comparator delays instead of six.

The first level has two kinds of unit:
- One unit compares the lowest four bits. Its cascade inputs are tied to the "no decision yet, equal so far" state.
- Four slice units each cover five bits. The upper four bits of a slice go on the data inputs. The lowest bit pair goes on the cascade inputs: the A bit on cascade-greater, the B bit on cascade-less, and cascade-equal held low.

When a slice's five bits match, the two outputs of its slice unit are equal to each other, either both high or both low. This is why a slice result may only feed the data inputs of another comparator.

The second-level unit takes the slice results on its data inputs, with the most significant slice on its top bit. It takes the low unit's three flags on its cascade inputs. It is purely combinational.

Top module: `wcmp_par24`

## Requirements
- R1: `gt_o` is high exactly when `a_i` is greater than `b_i` as unsigned 24-bit numbers.
- R2: `lt_o` is high exactly when `a_i` is less than `b_i` as unsigned 24-bit numbers.
- R3: `eq_o` is high exactly when `a_i` equals `b_i`, including the all-zero and all-one words.
- R4: For any input pair, exactly one of `gt_o`, `lt_o`, `eq_o` is high.
- R5: When bits 23..4 of both words match, bits 3..0 alone decide the result. This path runs through the low unit into the cascade inputs of the second-level unit.
- R6: A difference in bit 4, 9, 14 or 19 alone decides the result correctly. These bits reach a slice unit through its cascade inputs. A slice whose five bits match gives equal greater and less outputs. A slice whose bits differ gives opposite ones.
- R7: A difference in a more significant slice decides the result even when every less significant bit differs in the opposite direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 24 | First unsigned operand |
| b_i | input | 24 | Second unsigned operand |
| gt_o | output | 1 | High when a_i > b_i |
| lt_o | output | 1 | High when a_i < b_i |
| eq_o | output | 1 | High when a_i == b_i |

## Verification
The bench flips every single bit position in turn, in both directions. It does this on a zero background and on random equal backgrounds.

Each group of positions exposes a different fault:
- A miswired slice boundary or a swapped slice order makes one of these flips report the wrong direction.
- Swapped cascade pins on a slice unit invert the result for bits 4, 9, 14 and 19.
- A wrong tie-off on the low unit breaks equality, or breaks the cases decided by bits 3..0.

Words whose top bit differs while every lower bit differs the other way catch a design that lets the lower slices override the upper ones. Random pairs with shared high bits exercise the cascade paths under mixed data.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } cmp_res_t;

  localparam cmp_res_t CASC_IDLE = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};
endpackage

// File: rtl/wcmp_nibble.sv
// Cascadable magnitude unit; when the data match, the cascade inputs decide.
module wcmp_nibble
  import wcmp_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  cmp_res_t     casc_i,
  output cmp_res_t     res_o
);
  always_comb begin
    if (a_i > b_i) begin
      res_o = '{gt: 1'b1, lt: 1'b0, eq: 1'b0};
    end else if (a_i < b_i) begin
      res_o = '{gt: 1'b0, lt: 1'b1, eq: 1'b0};
    end else begin
      // cascade eq dominates; otherwise each flag is the absence of the opposite
      res_o.eq = casc_i.eq;
      res_o.gt = ~casc_i.eq & ~casc_i.lt;
      res_o.lt = ~casc_i.eq & ~casc_i.gt;
    end
  end
endmodule

// File: rtl/wcmp_slice.sv
// (W+1)-bit slice: the lowest bit pair enters through the cascade inputs.
module wcmp_slice
  import wcmp_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W:0] a_i,
  input  logic [W:0] b_i,
  output logic       gt_o,
  output logic       lt_o
);
  cmp_res_t casc;
  cmp_res_t res;

  assign casc = '{gt: a_i[0], lt: b_i[0], eq: 1'b0};

  wcmp_nibble #(.W(W)) u_unit (
    .a_i    (a_i[W:1]),
    .b_i    (b_i[W:1]),
    .casc_i (casc),
    .res_o  (res)
  );

  // res.eq is never high here: cascade eq is held low
  assign gt_o = res.gt;
  assign lt_o = res.lt;
endmodule

// File: rtl/wcmp_par24.sv
module wcmp_par24
  import wcmp_pkg::*;
#(
  parameter int unsigned WIDTH = 24,
  parameter int unsigned NIB_W = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o
);
  localparam int unsigned SLICE_W = NIB_W + 1;
  localparam int unsigned N_SLICE = (WIDTH - NIB_W) / SLICE_W;

  cmp_res_t          low_res;
  cmp_res_t          fin_res;
  logic [N_SLICE-1:0] sl_gt;
  logic [N_SLICE-1:0] sl_lt;
  logic [NIB_W-1:0]   fin_a;
  logic [NIB_W-1:0]   fin_b;

  wcmp_nibble #(.W(NIB_W)) u_low (
    .a_i    (a_i[NIB_W-1:0]),
    .b_i    (b_i[NIB_W-1:0]),
    .casc_i (CASC_IDLE),
    .res_o  (low_res)
  );

  for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
    localparam int unsigned LO = NIB_W + s * SLICE_W;
    wcmp_slice #(.W(NIB_W)) u_slice (
      .a_i  (a_i[LO +: SLICE_W]),
      .b_i  (b_i[LO +: SLICE_W]),
      .gt_o (sl_gt[s]),
      .lt_o (sl_lt[s])
    );
  end

  // slice s lands on final data bit s; upper bits unused when fewer slices
  for (genvar k = 0; k < NIB_W; k++) begin : g_map
    if (k < N_SLICE) begin : g_used
      assign fin_a[k] = sl_gt[k];
      assign fin_b[k] = sl_lt[k];
    end else begin : g_pad
      assign fin_a[k] = 1'b0;
      assign fin_b[k] = 1'b0;
    end
  end

  wcmp_nibble #(.W(NIB_W)) u_final (
    .a_i    (fin_a),
    .b_i    (fin_b),
    .casc_i (low_res),
    .res_o  (fin_res)
  );

  assign gt_o = fin_res.gt;
  assign lt_o = fin_res.lt;
  assign eq_o = fin_res.eq;
endmodule

// File: rtl/wcmp_par24_chk.sv
module wcmp_par24_chk #(
  parameter int unsigned WIDTH   = 24,
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned SLICE_W = 5,
  parameter int unsigned N_SLICE = 4
) (
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic               gt_o,
  input logic               lt_o,
  input logic               eq_o,
  input logic [N_SLICE-1:0] sl_gt,
  input logic [N_SLICE-1:0] sl_lt
);
  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      p_gt_r1:     assert (gt_o == (a_i > b_i));
      p_lt_r2:     assert (lt_o == (a_i < b_i));
      p_eq_r3:     assert (eq_o == (a_i == b_i));
      p_onehot_r4: assert ($countones({gt_o, lt_o, eq_o}) == 1);
      for (int s = 0; s < N_SLICE; s++) begin
        // R6: matching slice -> equal flags, differing slice -> opposite flags
        p_slice_tie_r6: assert ((sl_gt[s] == sl_lt[s]) ==
          (a_i[NIB_W + s*SLICE_W +: SLICE_W] == b_i[NIB_W + s*SLICE_W +: SLICE_W]));
      end
    end
  end
endmodule

bind wcmp_par24 wcmp_par24_chk #(
  .WIDTH(WIDTH), .NIB_W(NIB_W), .SLICE_W(SLICE_W), .N_SLICE(N_SLICE)
) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .gt_o  (gt_o),
  .lt_o  (lt_o),
  .eq_o  (eq_o),
  .sl_gt (sl_gt),
  .sl_lt (sl_lt)
);

// File: tb/sim_wcmp_par24.sv
module sim_wcmp_par24;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic         gt, lt, eq;
  int           n_vec = 0;
  int           n_bad = 0;
  int           cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wcmp_par24 u0 (.a_i(a), .b_i(b), .gt_o(gt), .lt_o(lt), .eq_o(eq));

  function automatic logic [2:0] expect_flags(logic [W-1:0] x, logic [W-1:0] y);
    return {x > y, x < y, x == y};
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
    logic [2:0] exp;
    @(negedge clk);
    a = x;
    b = y;
    #1;
    exp = expect_flags(x, y);
    n_vec++;
    if ({gt, lt, eq} != exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h actual gt/lt/eq=%b expected=%b", req, x, y, {gt, lt, eq}, exp);
    end
    if ($countones({gt, lt, eq}) != 1) begin
      n_bad++;
      $display("FAIL R4 a=%h b=%h actual gt/lt/eq=%b expected one-hot", x, y, {gt, lt, eq});
    end
  endtask

  function automatic string tag_for(int i);
    if (i < 4) return "R5";
    if (i == 4 || i == 9 || i == 14 || i == 19) return "R6";
    return "R1 R2";
  endfunction

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog actual cycles=%0d expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] bg, lo, hi;
    void'($urandom(32'd7319));
    a = '0;
    b = '0;
    apply('0, '0, "R3 zero");
    apply('1, '1, "R3 ones");
    apply('1, '0, "R1");
    apply('0, '1, "R2");

    for (int i = 0; i < W; i++) begin
      apply(W'(1) << i, '0, tag_for(i));
      apply('0, W'(1) << i, tag_for(i));
      bg = W'($urandom);
      apply(bg | (W'(1) << i), bg & ~(W'(1) << i), tag_for(i));
      apply(bg & ~(W'(1) << i), bg | (W'(1) << i), tag_for(i));
    end

    // R7: upper slice wins against opposite lower differences
    apply(24'h800000, 24'h7FFFFF, "R7");
    apply(24'h7FFFFF, 24'h800000, "R7");
    apply(24'h080000, 24'h07FFFF, "R7");
    apply(24'h000010, 24'h00000F, "R7");
    apply(24'h004000, 24'h003FFF, "R7");

    for (int n = 0; n < 400; n++) begin
      hi = W'($urandom);
      lo = W'($urandom);
      case (n % 4)
        0: apply(hi, lo, "R1 R2 R3");
        1: apply(hi, hi, "R3");
        2: apply({hi[W-1:4], lo[3:0]}, hi, "R5");
        default: apply({hi[W-1:10], lo[9:0]}, {hi[W-1:10], W'($urandom)} & 24'hFFFFFF, "R6 R7");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule